// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous EDO DRAM alive. After reset it leaves the memory bus alone for a programmable startup delay. It then takes the bus and runs a fixed number of warm-up refresh cycles back to back, without asking for permission. Only after that does it raise `ready`, which tells the access controller that normal traffic may begin.

Once ready, an interval timer adds one owed refresh to a small debt counter each period. While the debt is non-zero and the sequencer is idle, it raises `ref_req`. When the access controller answers with `ref_gnt`, the sequencer drives the strobes through one refresh in which CAS falls before RAS, and then hands the bus back. The memory's own internal row counter picks the row, so no address is produced. When the debt grows to a threshold, `ref_urgent` asks the controller to close its open page at the next opportunity.

All strobe outputs are active low and sit high whenever the bus is not owned. The controller selects the sequencer's strobes while `bus_own` is high. During refresh the data pins, the address and the output enable are don't-care.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, `ras_n`, `cas_n` and `we_n` are 1, and `ready`, `ref_req`, `ref_urgent` and `bus_own` are 0.
- R2: `bus_own` stays 0 for the first STARTUP_CYC clock edges after reset is released. It goes to 1 after edge STARTUP_CYC.
- R3: Exactly INIT_REFS refreshes run back to back after the startup wait, whatever the value of `ref_gnt`. `ready` rises after edge STARTUP_CYC + INIT_REFS×(T_PRE+T_CSR+T_RAS+T_RP) and never falls again.
- R4: Before `ras_n` falls, `cas_n` has been low for at least T_CSR cycles. `cas_n` stays low for as long as `ras_n` is low.
- R5: Each refresh holds `ras_n` low for exactly T_RAS cycles. After the warm-up, each granted refresh keeps `bus_own` high for exactly T_PRE+T_CSR+T_RAS+T_RP cycles.
- R6: `we_n` is 1 in every cycle in which `bus_own` is 1.
- R7: The debt rises by one every INTERVAL_CYC cycles, counted from the rise of `ready`. `ref_req` is 1 exactly when `ready` is 1, the debt is non-zero and no refresh is in progress. The first request appears after edge INTERVAL_CYC counted from that rise.
- R8: Every period of the timer leads to exactly one refresh, however long the grant is delayed, as long as the debt stays below 2^DEBT_W−1. The debt saturates at 2^DEBT_W−1, so with the defaults a long denial is repaid with exactly 7 refreshes.
- R9: `ref_urgent` is 1 exactly when the debt is at least URGENT_AT.
- R10: `ref_gnt` has no effect when `ref_req` is 0: `bus_own` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_gnt | input | 1 | Access controller grants the bus for one refresh |
| ref_req | output | 1 | Refresh owed and sequencer idle |
| ref_urgent | output | 1 | Debt at or above the threshold; close the open page soon |
| bus_own | output | 1 | Sequencer drives the strobes |
| ready | output | 1 | Warm-up complete; normal accesses allowed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |

## Verification
Every output is decoded combinationally from registered state. A result caused by a clock edge can therefore be observed on the falling edge right after it. The bench keeps a count of rising edges since reset release. It checks `bus_own` and `ready` on the edge before and the edge after their computed changes: STARTUP_CYC, then STARTUP_CYC+INIT_REFS×cycle length. It checks `ref_req` and `ref_urgent` the same way, one and four timer periods after `ready`. Strobe order, pulse widths and the length of each ownership window are measured by a falling-edge monitor in whole cycles. The debt-repayment checks are taken half a timer period after a period boundary, which leaves the drain time to settle.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int STARTUP_CYC  = 10000,
  parameter int INIT_REFS    = 8,
  parameter int INTERVAL_CYC = 750,
  parameter int T_PRE        = 1,
  parameter int T_CSR        = 1,
  parameter int T_RAS        = 3,
  parameter int T_RP         = 2,
  parameter int DEBT_W       = 3,
  parameter int URGENT_AT    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_urgent,
  output logic bus_own,
  output logic ready,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int PW = $clog2(STARTUP_CYC + 1);
  localparam int IW = $clog2(INTERVAL_CYC + 1);
  localparam int NW = $clog2(INIT_REFS + 1);
  localparam logic [DEBT_W-1:0] DEBT_MAX = {DEBT_W{1'b1}};

  typedef enum logic [2:0] {S_WAIT, S_IDLE, S_PRE, S_CAS, S_RAS, S_REC} st_t;

  st_t              state, nstate;
  logic [PW-1:0]    ph;
  logic [IW-1:0]    itmr;
  logic [NW-1:0]    init_cnt;
  logic [DEBT_W-1:0] debt;
  logic             last, tick, done;

  always_comb begin
    case (state)
      S_WAIT:  last = ph == PW'(STARTUP_CYC - 1);
      S_PRE:   last = ph == PW'(T_PRE - 1);
      S_CAS:   last = ph == PW'(T_CSR - 1);
      S_RAS:   last = ph == PW'(T_RAS - 1);
      S_REC:   last = ph == PW'(T_RP - 1);
      default: last = 1'b0;
    endcase
  end

  always_comb begin
    nstate = state;
    case (state)
      S_WAIT:  if (last) nstate = S_PRE;
      S_IDLE:  if (ref_req && ref_gnt) nstate = S_PRE;
      S_PRE:   if (last) nstate = S_CAS;
      S_CAS:   if (last) nstate = S_RAS;
      S_RAS:   if (last) nstate = S_REC;
      S_REC:   if (last) nstate = (!ready && init_cnt != NW'(INIT_REFS - 1)) ? S_PRE : S_IDLE;
      default: nstate = S_IDLE;
    endcase
  end

  assign tick = ready && itmr == '0;
  assign done = ready && state == S_REC && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_WAIT;
      ph       <= '0;
      init_cnt <= '0;
      ready    <= 1'b0;
    end else begin
      state <= nstate;
      ph    <= (nstate != state) ? '0 : ph + 1'b1;
      if (!ready && state == S_REC && last) begin
        init_cnt <= init_cnt + 1'b1;
        if (init_cnt == NW'(INIT_REFS - 1)) ready <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      itmr <= IW'(INTERVAL_CYC - 1);
      debt <= '0;
    end else begin
      if (!ready || itmr == '0) itmr <= IW'(INTERVAL_CYC - 1);
      else                      itmr <= itmr - 1'b1;
      if (tick && !done && debt != DEBT_MAX) debt <= debt + 1'b1;
      else if (done && !tick)                debt <= debt - 1'b1;
    end
  end

  assign bus_own    = state != S_WAIT && state != S_IDLE;
  assign ref_req    = ready && debt != '0 && state == S_IDLE;
  assign ref_urgent = debt >= DEBT_W'(URGENT_AT);
  assign ras_n      = state != S_RAS;
  assign cas_n      = !(state == S_CAS || state == S_RAS);
  assign we_n       = 1'b1;

  // R4
  cas_leads_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !cas_n && $past(!cas_n));
  // R4
  cas_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);
  // R3
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  // R7
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> ready && !bus_own);
  // R8
  debt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    debt == DEBT_MAX |=> debt >= DEBT_MAX - 1'b1);
  // R10
  no_req_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !bus_own && !ref_req |=> !bus_own);
endmodule

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;
  localparam int S = 200, NI = 8, I = 80, TP = 1, TC = 1, TR = 3, TRP = 2;
  localparam int CYC = TP + TC + TR + TRP;
  localparam int R = S + NI * CYC;
  localparam int K = 40;

  logic clk = 0, rst_n = 0, ref_gnt = 0;
  logic ref_req, ref_urgent, bus_own, ready, ras_n, cas_n, we_n;
  int n = 0, checks = 0, errors = 0;
  int rfalls = 0, cas_run = 0, ras_run = 0, own_run = 0;
  logic p_ras = 1, p_own = 0, p_ready = 0, ready_seen = 0;

  dram_refresh_seq #(.STARTUP_CYC(S), .INIT_REFS(NI), .INTERVAL_CYC(I), .T_PRE(TP),
    .T_CSR(TC), .T_RAS(TR), .T_RP(TRP), .DEBT_W(3), .URGENT_AT(4)) dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .bus_own(bus_own), .ready(ready),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n));

  always #10 clk = ~clk;
  always @(posedge clk) if (rst_n) n <= n + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, n);
    end
  endtask

  function automatic bit exp_ready(input int c);
    return c >= R;
  endfunction

  task automatic wait_until(input int c);
    while (n < c) @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (bus_own) chk(we_n == 1'b1, "R6 we_n high", we_n, 1);
    if (!ras_n) chk(cas_n == 1'b0, "R4 cas low during ras", cas_n, 0);
    if (p_ras && !ras_n) begin
      rfalls++;
      chk(cas_run >= TC, "R4 cas lead cycles", cas_run, TC);
    end
    if (!p_ras && ras_n) chk(ras_run == TR, "R5 ras low width", ras_run, TR);
    if (p_own && !bus_own)
      chk(own_run == (p_ready ? CYC : NI * CYC), "R5 ownership length", own_run,
          p_ready ? CYC : NI * CYC);
    if (ready_seen) chk(ready == 1'b1, "R3 ready never falls", ready, 1);
    if (ready) ready_seen = 1;
    cas_run = cas_n ? 0 : cas_run + 1;
    ras_run = ras_n ? 0 : ras_run + 1;
    own_run = bus_own ? own_run + 1 : 0;
    p_ras = ras_n; p_own = bus_own; p_ready = ready;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", n, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base, got;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({ras_n, cas_n, we_n} == 3'b111, "R1 strobes high", {ras_n, cas_n, we_n}, 7);
    chk({ready, ref_req, ref_urgent, bus_own} == 4'b0, "R1 flags low",
        {ready, ref_req, ref_urgent, bus_own}, 0);
    rst_n = 1;
    wait_until(S - 1);
    chk(bus_own == 0, "R2 bus idle before startup", bus_own, 0);
    wait_until(S);
    chk(bus_own == 1, "R2 init takes bus", bus_own, 1);
    wait_until(R - 1);
    chk(ready == exp_ready(n), "R3 ready before warm-up", ready, exp_ready(n));
    wait_until(R);
    chk(ready == exp_ready(n), "R3 ready after warm-up", ready, exp_ready(n));
    chk(rfalls == NI, "R3 warm-up refresh count, no grant", rfalls, NI);
    ref_gnt = 0;
    wait_until(R + I - 1);
    chk(ref_req == 0, "R7 no request before period", ref_req, 0);
    wait_until(R + I);
    chk(ref_req == 1, "R7 request at period", ref_req, 1);
    wait_until(R + 4 * I - 1);
    chk(ref_urgent == 0, "R9 urgent below threshold", ref_urgent, 0);
    wait_until(R + 4 * I);
    chk(ref_urgent == 1, "R9 urgent at threshold", ref_urgent, 1);
    wait_until(R + 10 * I + 1);
    base = rfalls;
    ref_gnt = 1;
    wait_until(R + 10 * I + 70);
    chk(rfalls - base == 7, "R8 saturated debt repaid", rfalls - base, 7);
    chk(ref_req == 0 && ref_urgent == 0, "R8 debt cleared", ref_req, 0);
    wait_until(R + 10 * I + 75);
    chk(bus_own == 0, "R10 grant without request ignored", bus_own, 0);
    base = rfalls;
    while (n < R + (K - 1) * I) begin
      ref_gnt = ($urandom % 4) == 0;
      @(negedge clk);
    end
    ref_gnt = 1;
    wait_until(R + K * I + I / 2);
    got = rfalls - base;
    chk(got == K - 10, "R8 no refresh lost under random grants", got, K - 10);
    chk(ref_req == 0, "R7 request clear after drain", ref_req, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule